// File: doc/BRIEF.md
# Order-k Exp-Golomb Field Decoder

This block decodes one variable-length field per request from the front of a bitstream. The bitstream arrives as a 32-bit window whose most significant bit is the next unread bit. In Exp-Golomb mode the caller gives an order k from 0 to 3. The block counts the zeros in front of the first one, works out the codeword length and returns the code number. It also returns the signed value that the code number stands for.

In fixed-length mode the caller gives a bit count n instead. The block returns the top n bits of the window, unchanged, through the same shifter. In both modes the length output is meant for the consumed-length input of the upstream bitstream shifter.

The result is registered and appears exactly one cycle after the request. It holds its value until the next request. A request that cannot be decoded from the window reports an error, a zero length and zero values. There are two such cases: an Exp-Golomb prefix that is not ended within the top 16 bits, and a length greater than 32.

Top module: `expg_field_dec`

## Requirements
- R1: While reset is held, and until the first request after reset, `res_valid` is 0 and `res_len`, `res_code`, `res_signed` and `res_err` are all 0.
- R2: `res_valid` is 1 in exactly the cycle after a cycle with `req_valid` = 1, and 0 otherwise. Every result output keeps its value in cycles that follow a cycle without a request.
- R3: In Exp-Golomb mode (`len_mode` = 0), z is the number of zero bits above the first one bit in `win[31:16]`. The reported length is 2·z + k + 1, where k = `k_ord`.
- R4: In Exp-Golomb mode, `res_code` equals (`win` >> (32 − length)) − 2^k.
- R5: The orders k = 0, 1, 2 and 3 are all supported, selected by the 2-bit input `k_ord`.
- R6: In fixed-length mode (`len_mode` = 1), `res_len` equals `fix_len` and `res_code` is the top `fix_len` bits of `win`, right-aligned. A `fix_len` of 0 gives a code of 0. In this mode `k_ord` has no effect.
- R7: `res_code` is also the unsigned syntax-element value. `res_signed` (two's complement) is (c+1)/2 for an odd code c and −c/2 for an even code c.
- R8: In Exp-Golomb mode, if `win[31:16]` is all zero, then `res_err` = 1 and `res_len`, `res_code` and `res_signed` are 0.
- R9: If the length would exceed 32 (Exp-Golomb with z = 15 and k ≥ 2, or `fix_len` > 32), then `res_err` = 1 and `res_len`, `res_code` and `res_signed` are 0. `res_len` never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Decode request for this cycle |
| len_mode | input | 1 | 0 = Exp-Golomb, 1 = fixed length |
| k_ord | input | 2 | Exp-Golomb order k |
| fix_len | input | 6 | Bit count for fixed-length mode |
| win | input | 32 | Bitstream window, next bit at bit 31 |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_len | output | 6 | Bits consumed by this field |
| res_code | output | 32 | Code number, which is also the unsigned value |
| res_signed | output | 32 | Signed mapped value |
| res_err | output | 1 | Field could not be decoded from the window |

## Verification
Error detection and the length/value computation act on the same request in the same cycle. The case that brings them together is a prefix of 15 zeros: with k = 0 or 1 it gives a legal length of 31 or 32, and with k = 2 or 3 the same window must become an error with all outputs zero. The bench drives these windows back to back and also drives a fixed length of 33. It judges each result against a queue of expected values, which it computes from the length and value rules. Another pair that shares a cycle is the subtraction of 2^k and the signed mapping. Windows whose raw value is exactly 2^k must yield code 0 and signed value 0 for every order.

// File: rtl/expg_pkg.sv
package expg_pkg;
  localparam int unsigned WIN_W  = 32;
  localparam int unsigned DET_W  = 16;
  localparam int unsigned GRP_W  = 8;
  localparam int unsigned K_W    = 2;
endpackage

// File: rtl/expg_rst_sync.sv
module expg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/expg_prio_enc.sv
module expg_prio_enc #(
  parameter int unsigned W = 8,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] zeros,
  output logic          any
);
  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      if (bits[i]) zeros = CW'(W - 1 - i);
    end
  end

  assign any = |bits;
endmodule

// File: rtl/expg_lead_det.sv
module expg_lead_det #(
  parameter int unsigned DET_W = 16,
  parameter int unsigned GRP_W = 8,
  localparam int unsigned NGRP = DET_W / GRP_W,
  localparam int unsigned CW   = $clog2(GRP_W),
  localparam int unsigned ZW   = $clog2(DET_W)
) (
  input  logic [DET_W-1:0] bits,
  output logic [ZW-1:0]    zcount,
  output logic             none
);
  logic [CW-1:0] grp_zeros [NGRP];
  logic [NGRP-1:0] grp_any;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    expg_prio_enc #(.W(GRP_W)) u_enc (
      .bits  (bits[g*GRP_W +: GRP_W]),
      .zeros (grp_zeros[g]),
      .any   (grp_any[g])
    );
  end

  always_comb begin
    zcount = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) zcount = ZW'((NGRP - 1 - g) * GRP_W) + ZW'(grp_zeros[g]);
    end
  end

  assign none = ~|grp_any;

  always_comb begin
    if (!none) begin
      a_r3_first_one_hit : assert (bits[DET_W - 1 - int'(zcount)] == 1'b1);
    end
  end
endmodule

// File: rtl/expg_extract.sv
module expg_extract #(
  parameter int unsigned WIN_W = 32,
  localparam int unsigned LEN_W = $clog2(WIN_W + 1)
) (
  input  logic [WIN_W-1:0] win,
  input  logic [LEN_W-1:0] len,
  output logic [WIN_W-1:0] field
);
  logic [LEN_W-1:0] shamt;

  always_comb begin
    shamt = LEN_W'(WIN_W) - len;
    if (len == '0) field = '0;
    else           field = win >> shamt;
  end
endmodule

// File: rtl/expg_field_dec.sv
module expg_field_dec
  import expg_pkg::*;
#(
  parameter int unsigned P_WIN_W = WIN_W,
  parameter int unsigned P_DET_W = DET_W,
  parameter int unsigned P_GRP_W = GRP_W,
  parameter int unsigned P_K_W   = K_W,
  localparam int unsigned LEN_W  = $clog2(P_WIN_W + 1),
  localparam int unsigned ZW     = $clog2(P_DET_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               len_mode,
  input  logic [P_K_W-1:0]   k_ord,
  input  logic [LEN_W-1:0]   fix_len,
  input  logic [P_WIN_W-1:0] win,
  output logic               res_valid,
  output logic [LEN_W-1:0]   res_len,
  output logic [P_WIN_W-1:0] res_code,
  output logic [P_WIN_W-1:0] res_signed,
  output logic               res_err
);
  logic rst_i_n;

  expg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // prefix detection
  logic [ZW-1:0] zcount;
  logic          no_one;

  expg_lead_det #(.DET_W(P_DET_W), .GRP_W(P_GRP_W)) u_det (
    .bits   (win[P_WIN_W-1 -: P_DET_W]),
    .zcount (zcount),
    .none   (no_one)
  );

  // length selection
  logic [LEN_W-1:0] eg_len, sel_len;
  logic             too_long, err_d;

  always_comb begin
    eg_len   = LEN_W'({zcount, 1'b0}) + LEN_W'(k_ord) + LEN_W'(1);
    sel_len  = len_mode ? fix_len : eg_len;
    too_long = sel_len > LEN_W'(P_WIN_W);
    err_d    = too_long | (~len_mode & no_one);
  end

  // shared right shifter
  logic [P_WIN_W-1:0] raw_field;

  expg_extract #(.WIN_W(P_WIN_W)) u_ext (
    .win   (win),
    .len   (sel_len),
    .field (raw_field)
  );

  // code number and signed mapping
  logic [P_WIN_W-1:0] code_d, half, signed_d;

  always_comb begin
    code_d   = len_mode ? raw_field : raw_field - (P_WIN_W'(1) << k_ord);
    half     = code_d >> 1;
    signed_d = code_d[0] ? half + P_WIN_W'(1) : P_WIN_W'(0) - half;
  end

  // next state
  logic [LEN_W-1:0]   len_n;
  logic [P_WIN_W-1:0] code_n, signed_n;
  logic               err_n, valid_n, mode_n;
  logic [P_K_W-1:0]   k_n;
  logic               mode_q;
  logic [P_K_W-1:0]   k_q;

  always_comb begin
    valid_n  = req_valid;
    len_n    = res_len;
    code_n   = res_code;
    signed_n = res_signed;
    err_n    = res_err;
    mode_n   = mode_q;
    k_n      = k_q;
    if (req_valid) begin
      err_n  = err_d;
      mode_n = len_mode;
      k_n    = k_ord;
      if (err_d) begin
        len_n    = '0;
        code_n   = '0;
        signed_n = '0;
      end else begin
        len_n    = sel_len;
        code_n   = code_d;
        signed_n = signed_d;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_valid  <= 1'b0;
      res_len    <= '0;
      res_code   <= '0;
      res_signed <= '0;
      res_err    <= 1'b0;
      mode_q     <= 1'b0;
      k_q        <= '0;
    end else begin
      res_valid  <= valid_n;
      res_len    <= len_n;
      res_code   <= code_n;
      res_signed <= signed_n;
      res_err    <= err_n;
      mode_q     <= mode_n;
      k_q        <= k_n;
    end
  end

  // assertions
  a_r2_valid_follows : assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> res_valid);
  a_r2_valid_idle : assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |=> !res_valid);
  a_r2_hold : assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |=> ($stable(res_len) && $stable(res_code) && $stable(res_err)));
  a_r8_err_zero : assert property (@(posedge clk) disable iff (!rst_i_n)
    res_err |-> (res_len == '0 && res_code == '0 && res_signed == '0));
  a_r3_len_parity : assert property (@(posedge clk) disable iff (!rst_i_n)
    (res_valid && !mode_q && !res_err) |-> (res_len[0] != k_q[0]));
  a_r9_len_bound : assert property (@(posedge clk) disable iff (!rst_i_n)
    res_len <= LEN_W'(P_WIN_W));
  a_r6_fixed_len : assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && len_mode && fix_len <= LEN_W'(P_WIN_W)) |=> (res_len == $past(fix_len)));
endmodule

// File: tb/sim_expg_field_dec.sv
module sim_expg_field_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        len_mode = 1'b0;
  logic [1:0]  k_ord = '0;
  logic [5:0]  fix_len = '0;
  logic [31:0] win = '0;
  logic        res_valid;
  logic [5:0]  res_len;
  logic [31:0] res_code, res_signed;
  logic        res_err;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [5:0] last_len = '0;
  logic [31:0] rng = 32'h1234_5678;

  logic [5:0]  q_len [$];
  logic [31:0] q_code [$];
  logic [31:0] q_sgn [$];
  logic        q_err [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  expg_field_dec u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .len_mode(len_mode),
    .k_ord(k_ord), .fix_len(fix_len), .win(win), .res_valid(res_valid),
    .res_len(res_len), .res_code(res_code), .res_signed(res_signed), .res_err(res_err)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic fm, input logic [1:0] k, input logic [5:0] n, input logic [31:0] w,
                       output logic [5:0] el, output logic [31:0] ec, output logic [31:0] es, output logic ee);
    int z;
    int l;
    bit found;
    logic [31:0] v;
    ee = 1'b0; el = '0; ec = '0; es = '0;
    if (fm) begin
      l = int'(n);
    end else begin
      z = 0; found = 0;
      for (int i = 31; i >= 16; i--) begin
        if (!found) begin
          if (w[i]) found = 1;
          else z++;
        end
      end
      if (!found) ee = 1'b1;
      l = 2 * z + int'(k) + 1;
    end
    if (l > 32) ee = 1'b1;
    if (!ee) begin
      v = (l == 0) ? 32'd0 : (w >> (32 - l));
      ec = fm ? v : v - (32'd1 << k);
      el = 6'(l);
      es = ec[0] ? (ec >> 1) + 32'd1 : 32'd0 - (ec >> 1);
    end
  endtask

  task automatic drive(input logic fm, input logic [1:0] k, input logic [5:0] n, input logic [31:0] w, input string tag);
    logic [5:0] el; logic [31:0] ec, es; logic ee;
    @(negedge clk);
    req_valid = 1'b1; len_mode = fm; k_ord = k; fix_len = n; win = w;
    model(fm, k, n, w, el, ec, es, ee);
    q_len.push_back(el); q_code.push_back(ec); q_sgn.push_back(es);
    q_err.push_back(ee); q_tag.push_back(tag);
    last_len = el;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      win = 32'hA5A5_A5A5;
      k_ord = 2'd3;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q_len.size() == 0) begin
        check("R2", "unexpected result", 32'd1, 32'd0);
      end else begin
        string t;
        t = q_tag.pop_front();
        check(t, "len", 32'(res_len), 32'(q_len.pop_front()));
        check(t, "code", res_code, q_code.pop_front());
        check(t, "signed", res_signed, q_sgn.pop_front());
        check(t, "err", 32'(res_err), 32'(q_err.pop_front()));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "valid in reset", 32'(res_valid), 32'd0);
    check("R1", "len in reset", 32'(res_len), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "code after reset", res_code, 32'd0);
    check("R1", "err after reset", 32'(res_err), 32'd0);
    check("R1", "valid after reset", 32'(res_valid), 32'd0);

    // R3/R4/R7 order 0
    drive(0, 0, 0, 32'h8000_0000, "R3");
    drive(0, 0, 0, 32'h4000_0000, "R4");
    drive(0, 0, 0, 32'h6000_0000, "R7");
    drive(0, 0, 0, 32'h2000_0000, "R7");
    drive(0, 0, 0, 32'h0001_FFFF, "R3");
    // R5 higher orders, including raw value == 2^k
    drive(0, 1, 0, 32'h8000_0000, "R5");
    drive(0, 1, 0, 32'hC000_0000, "R5");
    drive(0, 2, 0, 32'h9000_0000, "R5");
    drive(0, 3, 0, 32'h8000_0000, "R5");
    drive(0, 3, 0, 32'h1F00_0000, "R5");
    drive(0, 1, 0, 32'h0001_8000, "R9");
    // R9 overflow with legal prefix, R8 missing prefix
    drive(0, 2, 0, 32'h0001_FFFF, "R9");
    drive(0, 3, 0, 32'h0001_0000, "R9");
    drive(0, 0, 0, 32'h0000_FFFF, "R8");
    idle(2);
    // R2 hold after gap
    check("R2", "idle valid", 32'(res_valid), 32'd0);
    check("R2", "held len", 32'(res_len), 32'(last_len));

    // R6 fixed length, k ignored
    drive(1, 0, 6'd5, 32'hD800_0000, "R6");
    drive(1, 3, 6'd5, 32'hD800_0000, "R6");
    drive(1, 2, 6'd0, 32'hFFFF_FFFF, "R6");
    drive(1, 1, 6'd32, 32'hDEAD_BEEF, "R6");
    drive(1, 0, 6'd33, 32'hDEAD_BEEF, "R9");
    drive(1, 0, 6'd1, 32'h8000_0000, "R6");
    idle(1);

    // mixed patterns
    for (int j = 0; j < 200; j++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      drive(rng[0], rng[2:1], 6'(rng[8:3] % 6'd34), rng >> rng[13:9] % 32'd20, rng[0] ? "R6" : "R4");
      if (rng[15]) idle(1);
    end
    idle(3);
    check("R2", "queue drained", 32'(q_len.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule